// File: doc/BRIEF.md
# Strobed Mode and Position Controller

This block sits behind the configuration pins of a television video encoder. It brings eight mode pins into the system clock domain: an active-low clock-output enable, an underscan select, a two-bit anti-flicker filter select, and four active-low picture-nudge buttons. A strobe pin controls when they are seen. While the strobe is high the pins act live. When the strobe falls, their state is frozen, so the board can let go of the pins and the chip keeps its setting.

The four buttons move the picture one step per press. The steps accumulate in two signed six-bit offsets, one horizontal and one vertical, which saturate at their limits. The block also drives a clock output. The first assertion of the enable after reset routes the reference clock (source 0) to it. Each later assertion moves the output on to the next of the internal test clocks, and after the last one it returns to the reference. The selection changes only while both the outgoing and the incoming source are low. The output is forced low when the enable is released or when the power-down pin is low.

Top module: `modepos_ctrl`

## Requirements
- R1: Each pin input passes through two flops clocked by `clk`, so a pin change shows on the outputs after the second rising edge. Right after reset, `mode_o` is 8'hCF, both offsets are 0 and `clk_o` is 0.
- R2: While `strobe_i` is high, `mode_o` follows the synchronized pins.
- R3: While `strobe_i` is low, `mode_o` keeps the value captured when the strobe fell, and pin changes (including button presses) have no effect.
- R4: The layout of `mode_o` is bit 7 clock enable (active low), bit 6 underscan, bits 5:4 anti-flicker select, bit 3 up, bit 2 down, bit 1 left and bit 0 right, the last four active low. `af_mode_o` equals bits 5:4. `underscan_o` is 1 for underscan (about 12.5% horizontal) and 0 for overscan.
- R5: Each high-to-low transition of a button changes its offset by exactly one. Up lowers `voff_o`, down raises it, left lowers `hoff_o` and right raises it. A held button gives a single step.
- R6: The offsets saturate at +31 and -32. They never wrap.
- R7: Presses of opposite buttons on the same axis in the same cycle cancel out and leave that offset unchanged.
- R8: After reset, the first assertion (low) of the enable routes source 0 to `clk_o`. `clk_o` is 0 while the enable is high or while `pd_n_i` is low.
- R9: Each further assertion of the enable advances the selection to the next source (0, 1, ..., NSRC-1), then wraps back to 0.
- R10: The active source changes only in a cycle where both the old and the new source sample low. Until then `clk_o` keeps following the old source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | High: mode pins live. Falling edge: freeze them |
| clken_n_i | input | 1 | Clock-output enable, active low |
| underscan_i | input | 1 | Underscan select |
| af_sel_i | input | 2 | Anti-flicker filter select |
| up_n_i | input | 1 | Up button, active low |
| down_n_i | input | 1 | Down button, active low |
| left_n_i | input | 1 | Left button, active low |
| right_n_i | input | 1 | Right button, active low |
| pd_n_i | input | 1 | Power-down, active low |
| src_clk_i | input | NSRC | Candidate clocks. Bit 0 is the reference |
| mode_o | output | 8 | Effective mode word |
| af_mode_o | output | 2 | Selected anti-flicker mode |
| underscan_o | output | 1 | 1 = underscan, 0 = overscan |
| hoff_o | output | OFFW | Signed horizontal offset |
| voff_o | output | OFFW | Signed vertical offset |
| clk_o | output | 1 | Gated, selected clock output |

## Verification
The assertions assume that every pin, including the candidate clocks, stays at each level for at least two system-clock cycles. Without that, the synchronizer could miss a falling edge, or a source could pulse high and low between two samples. The stimulus holds each button level for four cycles and each clock-source pattern for five. It never changes the strobe in the same cycle as the pins it is meant to freeze. The check on glitch-free switching also assumes the sources pass through a common low phase. The bench makes that happen by parking all sources low before each selection test.

// File: rtl/modepos_pkg.sv
package modepos_pkg;
  typedef struct packed {
    logic       clken_n;
    logic       undersc;
    logic [1:0] af_sel;
    logic       up_n;
    logic       dn_n;
    logic       lf_n;
    logic       rt_n;
  } mode_word_t;

  localparam logic [7:0] MODE_IDLE = 8'hCF;
endpackage

// File: rtl/mp_sync.sv
module mp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST;
      s2 <= RST;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/mp_latch.sv
module mp_latch
  import modepos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_s,
  input  mode_word_t pins_s,
  output mode_word_t mode_eff
);
  mode_word_t hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= mode_word_t'(MODE_IDLE);
    else if (strobe_s) hold_q <= pins_s;
  end

  assign mode_eff = strobe_s ? pins_s : hold_q;

  // R3: once strobe is low the effective word cannot move
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_s |-> (mode_eff == $past(mode_eff)));
endmodule

// File: rtl/mp_axis.sv
module mp_axis #(
  parameter int W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc_n,
  input  logic                dec_n,
  output logic signed [W-1:0] off_o
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] ONE  = 1;

  function automatic logic signed [W-1:0] step_off(
    input logic signed [W-1:0] cur, input logic up, input logic dn);
    if (up && !dn && cur != MAXV) return cur + ONE;
    if (dn && !up && cur != MINV) return cur - ONE;
    return cur;
  endfunction

  logic inc_prev, dec_prev;
  logic inc_evt, dec_evt;
  logic signed [W-1:0] off_q;

  assign inc_evt = inc_prev & ~inc_n;
  assign dec_evt = dec_prev & ~dec_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_prev <= 1'b1;
      dec_prev <= 1'b1;
      off_q    <= '0;
    end else begin
      inc_prev <= inc_n;
      dec_prev <= dec_n;
      off_q    <= step_off(off_q, inc_evt, dec_evt);
    end
  end

  assign off_o = off_q;

  // R5/R7: without exactly one press event, the offset holds
  p_step_only_on_press_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_evt ^ dec_evt) |=> $stable(off_q));
  p_no_wrap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q == MAXV) |=> (off_q == MAXV || off_q == MAXV - ONE));
  p_no_wrap_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q == MINV) |=> (off_q == MINV || off_q == MINV + ONE));
endmodule

// File: rtl/mp_clksel.sv
module mp_clksel #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clken_n,
  input  logic            pd_s,
  input  logic [NSRC-1:0] src_s,
  output logic            clk_o
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [SW-1:0] LAST = SW'(NSRC - 1);
  localparam logic [SW-1:0] ONE  = SW'(1);

  logic          en_prev, armed;
  logic [SW-1:0] sel_req, sel_cur;
  logic          en_evt, old_low, new_low;
  logic          clk_q;

  assign en_evt  = en_prev & ~clken_n;
  assign old_low = ~src_s[sel_cur];
  assign new_low = ~src_s[sel_req];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev <= 1'b1;
      armed   <= 1'b0;
      sel_req <= '0;
      sel_cur <= '0;
      clk_q   <= 1'b0;
    end else begin
      en_prev <= clken_n;
      if (en_evt) begin
        if (armed) sel_req <= (sel_req == LAST) ? '0 : sel_req + ONE;
        else       armed   <= 1'b1;
      end
      if (sel_cur != sel_req && old_low && new_low) sel_cur <= sel_req;
      clk_q <= ~clken_n & pd_s & src_s[sel_cur];
    end
  end

  assign clk_o = clk_q;

  // R8: power-down forces the output low on the next edge
  p_pd_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_s |=> !clk_q);
  // R10: selection moves only across a common low phase
  p_glitchless_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cur != $past(sel_cur)) |-> $past(old_low && new_low));
endmodule

// File: rtl/modepos_ctrl.sv
module modepos_ctrl
  import modepos_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int OFFW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe_i,
  input  logic                   clken_n_i,
  input  logic                   underscan_i,
  input  logic [1:0]             af_sel_i,
  input  logic                   up_n_i,
  input  logic                   down_n_i,
  input  logic                   left_n_i,
  input  logic                   right_n_i,
  input  logic                   pd_n_i,
  input  logic [NSRC-1:0]        src_clk_i,
  output logic [7:0]             mode_o,
  output logic [1:0]             af_mode_o,
  output logic                   underscan_o,
  output logic signed [OFFW-1:0] hoff_o,
  output logic signed [OFFW-1:0] voff_o,
  output logic                   clk_o
);
  mode_word_t      pins_raw, pins_s, mode_eff;
  logic            strobe_s, pd_s;
  logic [NSRC-1:0] src_s;

  assign pins_raw = '{clken_n: clken_n_i, undersc: underscan_i, af_sel: af_sel_i,
                      up_n: up_n_i, dn_n: down_n_i, lf_n: left_n_i, rt_n: right_n_i};

  mp_sync #(.W(8), .RST(MODE_IDLE)) u_sync_pins (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));
  mp_sync #(.W(1), .RST(1'b1)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d(strobe_i), .q(strobe_s));
  mp_sync #(.W(1), .RST(1'b1)) u_sync_pd (
    .clk(clk), .rst_n(rst_n), .d(pd_n_i), .q(pd_s));
  mp_sync #(.W(NSRC), .RST('0)) u_sync_src (
    .clk(clk), .rst_n(rst_n), .d(src_clk_i), .q(src_s));

  mp_latch u_latch (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .pins_s(pins_s), .mode_eff(mode_eff));

  mp_axis #(.W(OFFW)) u_haxis (
    .clk(clk), .rst_n(rst_n), .inc_n(mode_eff.rt_n), .dec_n(mode_eff.lf_n), .off_o(hoff_o));
  mp_axis #(.W(OFFW)) u_vaxis (
    .clk(clk), .rst_n(rst_n), .inc_n(mode_eff.dn_n), .dec_n(mode_eff.up_n), .off_o(voff_o));

  mp_clksel #(.NSRC(NSRC)) u_clksel (
    .clk(clk), .rst_n(rst_n), .clken_n(mode_eff.clken_n), .pd_s(pd_s),
    .src_s(src_s), .clk_o(clk_o));

  assign mode_o      = mode_eff;
  assign af_mode_o   = mode_eff.af_sel;
  assign underscan_o = mode_eff.undersc;
endmodule

// File: tb/modepos_ctrl_bench.sv
`timescale 1ns/1ps
module modepos_ctrl_bench;
  localparam int NSRC = 4;
  localparam int OFFW = 6;

  logic clk = 0, rst_n = 0;
  logic strobe = 1, clken_n = 1, undersc = 1, pd_n = 1;
  logic [1:0] afs = 0;
  logic up_n = 1, dn_n = 1, lf_n = 1, rt_n = 1;
  logic [NSRC-1:0] src = 0;
  logic [7:0] mode_o;
  logic [1:0] af_mode_o;
  logic underscan_o, clk_o;
  logic signed [OFFW-1:0] hoff_o, voff_o;

  int n_chk = 0, n_bad = 0;
  int exp_h = 0, exp_v = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modepos_ctrl #(.NSRC(NSRC), .OFFW(OFFW)) u_modepos_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .clken_n_i(clken_n),
    .underscan_i(undersc), .af_sel_i(afs), .up_n_i(up_n), .down_n_i(dn_n),
    .left_n_i(lf_n), .right_n_i(rt_n), .pd_n_i(pd_n), .src_clk_i(src),
    .mode_o(mode_o), .af_mode_o(af_mode_o), .underscan_o(underscan_o),
    .hoff_o(hoff_o), .voff_o(voff_o), .clk_o(clk_o));

  function automatic int clamp(int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic logic [7:0] word(logic c, logic u, logic [1:0] a,
                                      logic up, logic dn, logic lf, logic rt);
    return {c, u, a, up, dn, lf, rt};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_off(string req);
    check(req, int'(hoff_o), exp_h);
    check(req, int'(voff_o), exp_v);
  endtask

  // dir: 0 up, 1 down, 2 left, 3 right
  task automatic press(int dir, int hold);
    case (dir)
      0: up_n = 0;
      1: dn_n = 0;
      2: lf_n = 0;
      default: rt_n = 0;
    endcase
    tick(hold);
    up_n = 1; dn_n = 1; lf_n = 1; rt_n = 1;
    tick(4);
    case (dir)
      0: exp_v = clamp(exp_v - 1);
      1: exp_v = clamp(exp_v + 1);
      2: exp_h = clamp(exp_h - 1);
      default: exp_h = clamp(exp_h + 1);
    endcase
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check("R1", mode_o, 8'hCF);
    chk_off("R1");
    check("R1", clk_o, 0);

    // R1 two-flop latency
    afs = 2'b10;
    tick(1);
    check("R1", af_mode_o, 0);
    tick(1);
    check("R1", af_mode_o, 2);

    // R4 underscan flag and field layout
    undersc = 0;
    tick(3);
    check("R4", underscan_o, 0);
    check("R4", mode_o, word(1, 0, 2'b10, 1, 1, 1, 1));

    // R2 live random mode patterns with strobe high
    for (int i = 0; i < 20; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      undersc = r[2]; afs = r[1:0];
      tick(3);
      check("R2", mode_o, word(1, r[2], r[1:0], 1, 1, 1, 1));
      check("R4", af_mode_o, r[1:0]);
      check("R4", underscan_o, r[2]);
    end

    // R5 random presses
    for (int i = 0; i < 40; i++) begin
      press(int'($urandom_range(0, 3)), 4);
      chk_off("R5");
    end
    // R5 held button gives one step
    press(3, 30);
    chk_off("R5");

    // R6 saturation both ends
    for (int i = 0; i < 70; i++) press(3, 4);
    check("R6", int'(hoff_o), 31);
    for (int i = 0; i < 70; i++) press(2, 4);
    check("R6", int'(hoff_o), -32);
    for (int i = 0; i < 70; i++) press(1, 4);
    check("R6", int'(voff_o), 31);
    chk_off("R6");

    // R7 opposite presses cancel
    up_n = 0; dn_n = 0;
    tick(4);
    up_n = 1; dn_n = 1;
    tick(4);
    chk_off("R7");

    // R3 freeze
    afs = 2'b01; undersc = 1;
    tick(4);
    strobe = 0;
    tick(4);
    afs = 2'b11; undersc = 0;
    tick(4);
    press(0, 4);
    exp_v = clamp(exp_v + 1); // undo model step: press must be ignored
    check("R3", mode_o, word(1, 1, 2'b01, 1, 1, 1, 1));
    chk_off("R3");
    strobe = 1;
    tick(4);
    check("R2", mode_o, word(1, 0, 2'b11, 1, 1, 1, 1));
    chk_off("R3");

    // R8 first enable routes source 0
    src = 0;
    clken_n = 0;
    tick(4);
    src = 4'b0001;
    tick(5);
    check("R8", clk_o, 1);
    src = 4'b0000;
    tick(5);
    check("R8", clk_o, 0);
    src = 4'b0001;
    pd_n = 0;
    tick(5);
    check("R8", clk_o, 0);
    pd_n = 1;
    tick(5);
    check("R8", clk_o, 1);
    clken_n = 1;
    tick(5);
    check("R8", clk_o, 0);

    // R10 second enable requests source 1 while source 0 is high
    clken_n = 0;
    tick(6);
    check("R10", clk_o, 1);
    src = 4'b0010;
    tick(6);
    check("R10", clk_o, 0);
    src = 4'b0000;
    tick(5);
    src = 4'b0010;
    tick(5);
    check("R9", clk_o, 1);
    src = 4'b0001;
    tick(5);
    check("R9", clk_o, 0);

    // R9 rotation 2, 3, then wrap to 0
    for (int k = 2; k <= 4; k++) begin
      int s;
      s = k % NSRC;
      src = 0;
      clken_n = 1;
      tick(4);
      clken_n = 0;
      tick(5);
      src = NSRC'(1 << s);
      tick(5);
      check("R9", clk_o, 1);
      src = ~NSRC'(1 << s);
      tick(5);
      check("R9", clk_o, 0);
    end

    done = 1;
    summary();
  end
endmodule